// File: doc/BRIEF.md
# Tree Allocation Mailbox Controller

This block is the shared control unit of an adaptive processor tree. Each processor leaves at most one request in a mailbox. The controller visits the mailboxes in a fixed circular order, one processor per clock cycle. When it finds a pending request it serves it in that same slot and acknowledges the requester with a one-cycle pulse. The processor then withdraws its request.

There are two kinds of work.

- **Son allocation.** A processor asks for a child in slot n. The controller takes the oldest number n' from its pool of idle processors and issues one link write. That write puts n' into slot n of the requester's mapping table. It also initialises the child: own number n', father k, position n, and its sensor bits cleared.
- **Sensor update.** A processor asks the controller to set or clear a sensor bit on its behalf. For a son, the target is that son's S bit. For the father, the target is the father's T bit at the requester's own position. The controller resolves either target from the links it recorded itself.

When several processors are waiting, service follows the scan order. A request waits at most one full scan of p processors.

Top module: `tam_ctrl`

## Requirements
- R1: After reset, ack, rsp_err, link_we and sens_we are all 0. All son slots and father links are invalid. No request is acknowledged during the NPROC-1 cycles in which the idle pool is loaded with numbers 1..NPROC-1. Processor 0 is the root and has no father.
- R2: The scan visits processors in circular order, one per cycle. A request raised on processor q is acknowledged within NPROC cycles. Two requests pending together are served in scan order, in different cycles.
- R3: An allocation (mb_kind 0) with a slot number 1..NSON in mb_arg, for a free slot, pops the pool in ascending order. It raises link_we with link_parent = requester, link_idx = slot and link_child = popped number.
- R4: The same link write records the child's father and position, so later father requests from the child reach the requester at that position.
- R5: An allocation for a slot that is already mapped is acknowledged without error. It raises no link_we and consumes no pool entry.
- R6: An allocation while the pool is empty is acknowledged with rsp_err = 1 and no link_we. The slot stays unmapped, so a later son request for that slot fails.
- R7: A son request (mb_kind 1) for a mapped slot mb_arg raises sens_we with sens_proc = son number, sens_sel = 0 (S bit) and sens_val = mb_val.
- R8: A father request (mb_kind 2) raises sens_we with sens_proc = stored father, sens_sel = stored position (T bit index 1..NSON) and sens_val = mb_val.
- R9: Each of the following is acknowledged with rsp_err = 1 and raises neither sens_we nor link_we:
  - a father request from a processor with no father;
  - a son request for an unmapped slot;
  - a slot number of 0 or above NSON;
  - mb_kind 3.
- R10: Every served request produces exactly one ack bit, that of the requester, for one cycle. The ack is aligned with rsp_err, link_we and sens_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mb_full | input | NPROC | Mailbox pending flag per processor |
| mb_kind | input | 2*NPROC | Request kind per processor: 0 allocate, 1 son sensor, 2 father sensor, 3 reserved |
| mb_val | input | NPROC | Sensor value to write, per processor |
| mb_arg | input | SW*NPROC | Son slot number 1..NSON, per processor |
| ack | output | NPROC | One-cycle acknowledge, one-hot |
| rsp_err | output | 1 | Request rejected (empty pool, bad target or kind) |
| link_we | output | 1 | Link write strobe (parent slot and child initialisation) |
| link_parent | output | PW | Requesting processor |
| link_idx | output | SW | Slot written in the parent, also the child's position |
| link_child | output | PW | Processor taken from the pool |
| sens_we | output | 1 | Sensor write strobe |
| sens_proc | output | PW | Processor whose sensor bit is written |
| sens_sel | output | SW | 0 selects S, i selects T_i |
| sens_val | output | 1 | Value written |

## Verification
The bench runs the pool dry and then checks that the rejected allocation left the slot unmapped. A design that mapped a stale or duplicate number would let the following son request through.

It repeats an allocation for a slot that is already mapped. A design that popped anyway would shift every later child number by one.

It issues father requests from the root and from an idle processor. A design that trusted invalid father entries would strobe processor 0 instead of flagging an error.

It raises two mailboxes in the same cycle and measures the gap between the two acks. Merged or dropped service shows up as a missing ack or a gap other than 1 or NPROC-1.

It also holds a request across reset release. A controller that serves before the pool is loaded would hand out garbage.

// File: rtl/tam_pkg.sv
package tam_pkg;
  typedef enum logic [1:0] {
    K_ALLOC  = 2'd0,
    K_SON    = 2'd1,
    K_FATHER = 2'd2,
    K_RSVD   = 2'd3
  } req_kind_e;
endpackage

// File: rtl/tam_scan.sv
module tam_scan #(
  parameter int NPROC = 8,
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(NPROC - 1);

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else     ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R2
  scan_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
  // R2
  scan_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr == LAST) |=> (ptr == '0));
endmodule

// File: rtl/tam_pool.sv
module tam_pool #(
  parameter int NPROC = 8,
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  output logic [PW-1:0] head,
  output logic          empty,
  output logic          ready
);
  localparam logic [PW-1:0] LAST = PW'(NPROC - 1);

  logic [PW-1:0] mem [NPROC];
  logic [PW-1:0] wr_ptr, rd_ptr, fill_val;
  logic [PW:0]   count;
  logic          filling;

  always_ff @(posedge clk) begin
    if (filling) mem[wr_ptr] <= fill_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      fill_val <= PW'(1);
      filling  <= 1'b1;
    end else if (filling) begin
      wr_ptr   <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      count    <= count + 1'b1;
      fill_val <= fill_val + 1'b1;
      if (fill_val == LAST) filling <= 1'b0;
    end else if (pop && count != '0) begin
      rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count  <= count - 1'b1;
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign ready = !filling;

  // R6
  pool_pop_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (!empty && ready));
endmodule

// File: rtl/tam_links.sv
module tam_links #(
  parameter int NPROC = 8,
  parameter int NSON  = 2,
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int SW = $clog2(NSON + 1),
  localparam int IW = $clog2(NPROC * NSON)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] w_parent,
  input  logic [SW-1:0] w_arg,
  input  logic [PW-1:0] w_child,
  input  logic [PW-1:0] q_proc,
  input  logic [SW-1:0] q_arg,
  output logic          son_valid,
  output logic [PW-1:0] son_num,
  output logic          fath_valid,
  output logic [PW-1:0] fath_num,
  output logic [SW-1:0] fath_pos
);
  logic [PW-1:0]         son_mem  [NPROC*NSON];
  logic [PW-1:0]         fath_mem [NPROC];
  logic [SW-1:0]         pos_mem  [NPROC];
  logic [NPROC*NSON-1:0] son_v;
  logic [NPROC-1:0]      fath_v;
  logic [IW-1:0]         widx, ridx;

  assign widx = IW'(w_parent) * IW'(NSON) + IW'(w_arg - 1'b1);
  assign ridx = IW'(q_proc) * IW'(NSON) + IW'(q_arg - 1'b1);

  always_ff @(posedge clk) begin
    if (we) begin
      son_mem[widx]     <= w_child;
      fath_mem[w_child] <= w_parent;
      pos_mem[w_child]  <= w_arg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      son_v  <= '0;
      fath_v <= '0;
    end else if (we) begin
      son_v[widx]    <= 1'b1;
      fath_v[w_child] <= 1'b1;
    end
  end

  assign son_valid  = son_v[ridx];
  assign son_num    = son_mem[ridx];
  assign fath_valid = fath_v[q_proc];
  assign fath_num   = fath_mem[q_proc];
  assign fath_pos   = pos_mem[q_proc];

  // R5
  link_no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> !son_v[widx]);
endmodule

// File: rtl/tam_ctrl.sv
module tam_ctrl
  import tam_pkg::*;
#(
  parameter int NPROC = 8,
  parameter int NSON  = 2,
  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int SW = $clog2(NSON + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPROC-1:0]    mb_full,
  input  logic [2*NPROC-1:0]  mb_kind,
  input  logic [NPROC-1:0]    mb_val,
  input  logic [SW*NPROC-1:0] mb_arg,
  output logic [NPROC-1:0]    ack,
  output logic                rsp_err,
  output logic                link_we,
  output logic [PW-1:0]       link_parent,
  output logic [SW-1:0]       link_idx,
  output logic [PW-1:0]       link_child,
  output logic                sens_we,
  output logic [PW-1:0]       sens_proc,
  output logic [SW-1:0]       sens_sel,
  output logic                sens_val
);
  logic [PW-1:0] ptr, head, son_num, fath_num, n_sproc;
  logic [SW-1:0] fath_pos, arg, n_ssel;
  logic          empty, ready, son_valid, fath_valid;
  logic          serve, arg_ok, pop, n_err, n_link, n_sens;
  req_kind_e     kind;

  tam_scan #(.NPROC(NPROC)) scan_i (.clk(clk), .rst(rst), .ptr(ptr));

  tam_pool #(.NPROC(NPROC)) pool_i (
    .clk(clk), .rst(rst), .pop(pop), .head(head), .empty(empty), .ready(ready));

  tam_links #(.NPROC(NPROC), .NSON(NSON)) links_i (
    .clk(clk), .rst(rst), .we(n_link), .w_parent(ptr), .w_arg(arg),
    .w_child(head), .q_proc(ptr), .q_arg(arg), .son_valid(son_valid),
    .son_num(son_num), .fath_valid(fath_valid), .fath_num(fath_num),
    .fath_pos(fath_pos));

  assign serve  = ready && mb_full[ptr];
  assign kind   = req_kind_e'(mb_kind[int'(ptr)*2 +: 2]);
  assign arg    = mb_arg[int'(ptr)*SW +: SW];
  assign arg_ok = (arg != '0) && (int'(arg) <= NSON);
  assign pop    = n_link;

  always_comb begin
    n_err   = 1'b0;
    n_link  = 1'b0;
    n_sens  = 1'b0;
    n_sproc = '0;
    n_ssel  = '0;
    if (serve) begin
      unique case (kind)
        K_ALLOC: begin
          if (!arg_ok)        n_err  = 1'b1;
          else if (son_valid) n_err  = 1'b0;
          else if (empty)     n_err  = 1'b1;
          else                n_link = 1'b1;
        end
        K_SON: begin
          if (!arg_ok || !son_valid) n_err = 1'b1;
          else begin
            n_sens  = 1'b1;
            n_sproc = son_num;
          end
        end
        K_FATHER: begin
          if (!fath_valid) n_err = 1'b1;
          else begin
            n_sens  = 1'b1;
            n_sproc = fath_num;
            n_ssel  = fath_pos;
          end
        end
        default: n_err = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack     <= '0;
      rsp_err <= 1'b0;
      link_we <= 1'b0;
      sens_we <= 1'b0;
    end else begin
      ack     <= serve ? (NPROC'(1) << ptr) : '0;
      rsp_err <= n_err;
      link_we <= n_link;
      sens_we <= n_sens;
    end
  end

  always_ff @(posedge clk) begin
    link_parent <= ptr;
    link_idx    <= arg;
    link_child  <= head;
    sens_proc   <= n_sproc;
    sens_sel    <= n_ssel;
    sens_val    <= mb_val[ptr];
  end

  // R10
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack));
  // R9
  err_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> ($countones(ack) == 1));
  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (!sens_we && !link_we));
  // R3
  link_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (ack != '0 && !sens_we));
  // R7
  sens_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    sens_we |-> ($countones(ack) == 1));
endmodule

// File: tb/tam_ctrl_tb_top.sv
`timescale 1ns/1ps
module tam_ctrl_tb_top;
  localparam int P  = 8;
  localparam int NS = 2;

  typedef struct packed {
    logic [3:0] rq;
    logic [2:0] proc;
    logic [1:0] kind;
    logic       val;
    logic [1:0] arg;
    logic       err;
    logic       lnk;
    logic [2:0] child;
    logic       sns;
    logic [2:0] sproc;
    logic [1:0] ssel;
    logic       sval;
  } vec_t;

  localparam int NV = 20;
  // fields: rq, proc, kind, val, arg, err, lnk, child, sns, sproc, ssel, sval
  localparam vec_t VEC [NV] = '{
    '{4'd3, 3'd0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b1, 3'd1, 1'b0, 3'd0, 2'd0, 1'b0}, // R3 (and R1 fill)
    '{4'd3, 3'd0, 2'd0, 1'b0, 2'd2, 1'b0, 1'b1, 3'd2, 1'b0, 3'd0, 2'd0, 1'b0}, // R3
    '{4'd3, 3'd1, 2'd0, 1'b0, 2'd1, 1'b0, 1'b1, 3'd3, 1'b0, 3'd0, 2'd0, 1'b0}, // R3
    '{4'd5, 3'd0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0}, // R5
    '{4'd7, 3'd0, 2'd1, 1'b1, 2'd2, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 2'd0, 1'b1}, // R7
    '{4'd8, 3'd3, 2'd2, 1'b1, 2'd0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd1, 2'd1, 1'b1}, // R8, R4
    '{4'd8, 3'd2, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd0, 2'd2, 1'b0}, // R8
    '{4'd9, 3'd0, 2'd2, 1'b1, 2'd0, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0}, // R9 root
    '{4'd9, 3'd1, 2'd1, 1'b1, 2'd2, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0}, // R9 unmapped
    '{4'd9, 3'd4, 2'd2, 1'b1, 2'd0, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0}, // R9 idle proc
    '{4'd9, 3'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0}, // R9 slot 0
    '{4'd9, 3'd0, 2'd1, 1'b1, 2'd3, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0}, // R9 slot 3
    '{4'd9, 3'd5, 2'd3, 1'b0, 2'd0, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0}, // R9 kind 3
    '{4'd3, 3'd1, 2'd0, 1'b0, 2'd2, 1'b0, 1'b1, 3'd4, 1'b0, 3'd0, 2'd0, 1'b0}, // R3
    '{4'd3, 3'd2, 2'd0, 1'b0, 2'd1, 1'b0, 1'b1, 3'd5, 1'b0, 3'd0, 2'd0, 1'b0}, // R3
    '{4'd3, 3'd2, 2'd0, 1'b0, 2'd2, 1'b0, 1'b1, 3'd6, 1'b0, 3'd0, 2'd0, 1'b0}, // R3
    '{4'd3, 3'd3, 2'd0, 1'b0, 2'd1, 1'b0, 1'b1, 3'd7, 1'b0, 3'd0, 2'd0, 1'b0}, // R3
    '{4'd6, 3'd3, 2'd0, 1'b0, 2'd2, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0}, // R6 empty
    '{4'd6, 3'd3, 2'd1, 1'b1, 2'd2, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 1'b0}, // R6 still unmapped
    '{4'd4, 3'd7, 2'd2, 1'b1, 2'd0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd3, 2'd1, 1'b1}  // R4
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [P-1:0]    mb_full = '0;
  logic [2*P-1:0]  mb_kind = '0;
  logic [P-1:0]    mb_val  = '0;
  logic [2*P-1:0]  mb_arg  = '0;
  logic [P-1:0]    ack;
  logic            rsp_err, link_we, sens_we, sens_val;
  logic [2:0]      link_parent, link_child, sens_proc;
  logic [1:0]      link_idx, sens_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tam_ctrl #(.NPROC(P), .NSON(NS)) dut_i (
    .clk(clk), .rst(rst), .mb_full(mb_full), .mb_kind(mb_kind),
    .mb_val(mb_val), .mb_arg(mb_arg), .ack(ack), .rsp_err(rsp_err),
    .link_we(link_we), .link_parent(link_parent), .link_idx(link_idx),
    .link_child(link_child), .sens_we(sens_we), .sens_proc(sens_proc),
    .sens_sel(sens_sel), .sens_val(sens_val));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic post(input int q, input int kind, input int val, input int arg);
    mb_kind[q*2 +: 2] = 2'(kind);
    mb_val[q]         = 1'(val);
    mb_arg[q*2 +: 2]  = 2'(arg);
    mb_full[q]        = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    mb_full = '0;
    repeat (3) @(negedge clk);
    chk("R1 ack idle", int'(ack), 0);
    chk("R1 strobes idle", int'({rsp_err, link_we, sens_we}), 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int a5, a6;
    do_reset();
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int lat;
      bit got;
      string tg;
      v   = VEC[i];
      tg  = $sformatf("R%0d vec%0d", v.rq, i);
      post(int'(v.proc), int'(v.kind), int'(v.val), int'(v.arg));
      lat = 0;
      got = 1'b0;
      for (int c = 0; c < 40 && !got; c++) begin
        @(negedge clk);
        lat++;
        if (ack != '0) got = 1'b1;
      end
      mb_full[v.proc] = 1'b0;
      chk({tg, " ack"}, int'(ack), 1 << v.proc);
      if (i == 0) chk("R1 no service during fill", int'(lat >= P), 1);
      else        chk("R2 latency", int'(lat <= P), 1);
      chk({tg, " err"}, int'(rsp_err), int'(v.err));
      chk({tg, " link"}, int'(link_we), int'(v.lnk));
      if (v.lnk) begin
        chk({tg, " parent"}, int'(link_parent), int'(v.proc));
        chk({tg, " idx"}, int'(link_idx), int'(v.arg));
        chk({tg, " child"}, int'(link_child), int'(v.child));
      end
      chk({tg, " sens"}, int'(sens_we), int'(v.sns));
      if (v.sns) begin
        chk({tg, " sproc"}, int'(sens_proc), int'(v.sproc));
        chk({tg, " ssel"}, int'(sens_sel), int'(v.ssel));
        chk({tg, " sval"}, int'(sens_val), int'(v.sval));
      end
      @(negedge clk);
      chk({tg, " R10 ack single cycle"}, int'(ack), 0);
    end

    // R2: two mailboxes raised together (5 -> father 2 pos 1, 6 -> father 2 pos 2)
    @(negedge clk);
    post(5, 2, 1, 0);
    post(6, 2, 0, 0);
    a5 = -1;
    a6 = -1;
    for (int c = 0; c < 3 * P; c++) begin
      @(negedge clk);
      chk("R2 one ack per cycle", int'($countones(ack) <= 1), 1);
      if (ack[5]) begin
        a5 = c;
        mb_full[5] = 1'b0;
        chk("R8 concurrent p5 target", int'({sens_we, sens_proc, sens_sel, sens_val}),
            int'({1'b1, 3'd2, 2'd1, 1'b1}));
      end
      if (ack[6]) begin
        a6 = c;
        mb_full[6] = 1'b0;
        chk("R8 concurrent p6 target", int'({sens_we, sens_proc, sens_sel, sens_val}),
            int'({1'b1, 3'd2, 2'd2, 1'b0}));
      end
    end
    chk("R2 both served", int'(a5 >= 0 && a6 >= 0), 1);
    chk("R2 scan-order gap", int'((a6 - a5 == 1) || (a5 - a6 == P - 1)), 1);

    // R1: reset clears the links
    do_reset();
    repeat (2 * P) @(negedge clk);
    post(0, 1, 1, 1);
    for (int c = 0; c < 2 * P && ack == '0; c++) @(negedge clk);
    mb_full[0] = 1'b0;
    chk("R1 links cleared by reset", int'({ack[0], rsp_err, sens_we}), int'(3'b110));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule